// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block keeps the most recent virtual-to-physical translations so that a hit never needs a table fetch. It is fully associative. Every slot records the size of the region it maps: a 4 KB page, a 64 KB page, a 1 MB section or a 16 MB supersection. One slot can therefore cover a whole large region. A lookup returns the hit flag, the physical address, the domain and the access bits in the same cycle the virtual address is presented. The lookup has no register between the address inputs and these outputs.

Each slot also holds a not-global flag and an 8-bit address-space tag. A global translation is shared by every address space. A process-specific translation hits only for the address space that created it. The table walker writes its results through a single fill port. Each fill goes into the slot chosen by a round-robin pointer. A flush input clears every slot at once. Permission checks and the walk itself are done outside this block.

Top module: `tlb_multisize`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses, and the round-robin pointer selects slot 0.
- R2: A slot compares the virtual address bits its stored size selects. Size code 0 (4 KB) compares va[31:12], code 1 (64 KB) compares va[31:16], code 2 (1 MB) compares va[31:20] and code 3 (16 MB) compares va[31:24]. The other bits of the virtual address are ignored.
- R3: On a hit, physical address bits above the region boundary come from the stored physical base, and the bits below the boundary come from the lookup address.
- R4: A slot whose not-global flag is 0 hits for any current address-space tag.
- R5: A slot whose not-global flag is 1 hits only when its stored 8-bit address-space tag equals the current tag.
- R6: On a hit the stored domain and access bits are returned. On a miss the physical address, domain and access bits are all zero.
- R7: The lookup result depends only on the current inputs and the stored contents, within the same cycle.
- R8: When a fill and a lookup occur in the same cycle, the lookup sees the contents from before the fill. The filled translation is visible from the next cycle.
- R9: Fills go to slots in order 0, 1, …, 31 and then wrap to 0, so the 33rd fill after the pointer is at 0 evicts the first.
- R10: A flush invalidates every slot in one cycle. A fill in the same cycle is dropped and does not move the pointer.
- R11: When several slots match, the lowest-numbered slot supplies the result.
- R12: A flush does not move the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_asid_i | input | 8 | Current address-space tag |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 32 | Translated physical address, zero on miss |
| domain_o | output | 4 | Domain of the hitting slot, zero on miss |
| attr_o | output | 6 | Access bits of the hitting slot, zero on miss |
| fill_i | input | 1 | Write a walker result |
| fill_va_i | input | 32 | Virtual address of the new translation |
| fill_pa_i | input | 32 | Physical base of the new translation |
| fill_size_i | input | 2 | Region size code (0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB) |
| fill_ng_i | input | 1 | Not-global flag: 1 = process specific |
| fill_asid_i | input | 8 | Address-space tag of the new translation |
| fill_domain_i | input | 4 | Domain of the new translation |
| fill_attr_i | input | 6 | Access bits of the new translation |
| flush_i | input | 1 | Invalidate every slot |

## Verification
The hardest state to reach from the ports is a table that holds overlapping translations of different sizes. In that state the lowest-slot priority decides the result, and a wrapped pointer has just evicted the oldest of them. Random fills drawn from a small pool of virtual addresses, with random sizes and tags, create many overlapping slots and repeated wraps. Directed sequences add three further cases: a deliberate 64 KB/4 KB overlap, a run of 33 fills after a flush to force the first eviction, and a flush in the same cycle as a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  localparam int unsigned VA_W  = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned PN_W  = VA_W - OFF_W;

  // page-number bits that take part in the compare for each size
  function automatic logic [PN_W-1:0] pn_mask(pg_size_e s);
    unique case (s)
      PG_4K:   pn_mask = {PN_W{1'b1}};
      PG_64K:  pn_mask = {{(PN_W-4){1'b1}}, 4'h0};
      PG_1M:   pn_mask = {{(PN_W-8){1'b1}}, 8'h0};
      default: pn_mask = {{(PN_W-12){1'b1}}, 12'h0};
    endcase
  endfunction

endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
#(
  parameter int unsigned ASID_W = 8
) (
  input  logic              valid_i,
  input  pg_size_e          size_i,
  input  logic              ng_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [PN_W-1:0]   tag_i,
  input  logic [PN_W-1:0]   lk_pn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              match_o
);

  logic [PN_W-1:0] mask;
  logic            pn_eq;
  logic            asid_ok;

  assign mask    = pn_mask(size_i);
  assign pn_eq   = ((tag_i ^ lk_pn_i) & mask) == '0;
  assign asid_ok = !ng_i || (asid_i == lk_asid_i);
  assign match_o = valid_i && pn_eq && asid_ok;

  always_comb begin
    if (match_o && ng_i) assert_ng_tag_R5 : assert (asid_i == lk_asid_i);
  end

endmodule

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_rr_step_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  assert_rr_hold_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0]        match_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic                hit_o,
  output logic [W-1:0]        data_o
);

  // lowest index wins: scan downward so it is written last
  always_comb begin
    data_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) data_o = data_i[i];
    end
  end

  assign hit_o = |match_i;

  always_comb begin
    if (!hit_o) assert_sel_zero_R6 : assert (data_o == '0);
  end

endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned DOM_W   = 4,
  parameter int unsigned ATTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic [31:0]       pa_o,
  output logic [DOM_W-1:0]  domain_o,
  output logic [ATTR_W-1:0] attr_o,
  input  logic              fill_i,
  input  logic [31:0]       fill_va_i,
  input  logic [31:0]       fill_pa_i,
  input  logic [1:0]        fill_size_i,
  input  logic              fill_ng_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [DOM_W-1:0]  fill_domain_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic              flush_i
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned SEL_W = PN_W + 2 + DOM_W + ATTR_W;

  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][1:0]         size_q;
  logic [ENTRIES-1:0]              ng_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][PN_W-1:0]    tag_q;
  logic [ENTRIES-1:0][PN_W-1:0]    base_q;
  logic [ENTRIES-1:0][DOM_W-1:0]   dom_q;
  logic [ENTRIES-1:0][ATTR_W-1:0]  attr_q;

  logic [IDX_W-1:0]                victim;
  logic                            do_fill;
  logic [ENTRIES-1:0]              match;
  logic [ENTRIES-1:0][SEL_W-1:0]   sel_data;
  logic [SEL_W-1:0]                sel;
  logic                            any_hit;

  assign do_fill = fill_i && !flush_i;

  tlb_rr_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (do_fill),
    .ptr_o  (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      ng_q   <= '0;
      asid_q <= '0;
      tag_q  <= '0;
      base_q <= '0;
      dom_q  <= '0;
      attr_q <= '0;
    end else if (do_fill) begin
      size_q[victim] <= fill_size_i;
      ng_q[victim]   <= fill_ng_i;
      asid_q[victim] <= fill_asid_i;
      tag_q[victim]  <= fill_va_i[31:OFF_W];
      base_q[victim] <= fill_pa_i[31:OFF_W];
      dom_q[victim]  <= fill_domain_i;
      attr_q[victim] <= fill_attr_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_entry_match #(.ASID_W(ASID_W)) u_match (
      .valid_i   (valid_q[g]),
      .size_i    (pg_size_e'(size_q[g])),
      .ng_i      (ng_q[g]),
      .asid_i    (asid_q[g]),
      .tag_i     (tag_q[g]),
      .lk_pn_i   (lk_va_i[31:OFF_W]),
      .lk_asid_i (lk_asid_i),
      .match_o   (match[g])
    );
    assign sel_data[g] = {base_q[g], size_q[g], dom_q[g], attr_q[g]};
  end

  tlb_hit_select #(.N(ENTRIES), .W(SEL_W)) u_sel (
    .match_i (match),
    .data_i  (sel_data),
    .hit_o   (any_hit),
    .data_o  (sel)
  );

  logic [PN_W-1:0]   sel_base;
  logic [1:0]        sel_size;
  logic [DOM_W-1:0]  sel_dom;
  logic [ATTR_W-1:0] sel_attr;
  logic [PN_W-1:0]   sel_mask;

  assign {sel_base, sel_size, sel_dom, sel_attr} = sel;
  assign sel_mask = pn_mask(pg_size_e'(sel_size));

  assign hit_o    = any_hit;
  assign domain_o = sel_dom;
  assign attr_o   = sel_attr;
  assign pa_o     = any_hit ?
      {(sel_base & sel_mask) | (lk_va_i[31:OFF_W] & ~sel_mask), lk_va_i[OFF_W-1:0]} : '0;

  assert_miss_zero_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0) && (domain_o == '0) && (attr_o == '0));

  assert_offset_pass_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[OFF_W-1:0] == lk_va_i[OFF_W-1:0]);

  assert_flush_empty_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  assert_fill_lands_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i) |=> valid_q[$past(victim)]);

endmodule

// File: tb/tlb_multisize_tb.sv
module tlb_multisize_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        hit;
  logic [31:0] pa;
  logic [3:0]  dom;
  logic [5:0]  attr;
  logic        fill = 1'b0;
  logic [31:0] fva = '0, fpa = '0;
  logic [1:0]  fsz = '0;
  logic        fng = 1'b0;
  logic [7:0]  fasid = '0;
  logic [3:0]  fdom = '0;
  logic [5:0]  fattr = '0;
  logic        flush = 1'b0;

  int n_vec  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tlb_multisize u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lk_va_i(lk_va), .lk_asid_i(lk_asid),
    .hit_o(hit), .pa_o(pa), .domain_o(dom), .attr_o(attr),
    .fill_i(fill), .fill_va_i(fva), .fill_pa_i(fpa), .fill_size_i(fsz),
    .fill_ng_i(fng), .fill_asid_i(fasid), .fill_domain_i(fdom),
    .fill_attr_i(fattr), .flush_i(flush)
  );

  // reference model
  logic        m_valid [32];
  logic [1:0]  m_size  [32];
  logic        m_ng    [32];
  logic [7:0]  m_asid  [32];
  logic [31:0] m_va    [32];
  logic [31:0] m_pa    [32];
  logic [3:0]  m_dom   [32];
  logic [5:0]  m_attr  [32];
  int          m_ptr = 0;

  function automatic logic [31:0] low_mask(logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_0FFF;
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'h000F_FFFF;
      default: return 32'h00FF_FFFF;
    endcase
  endfunction

  task automatic expect_lookup(input logic [31:0] va, input logic [7:0] asid,
                               output logic e_hit, output logic [31:0] e_pa,
                               output logic [3:0] e_dom, output logic [5:0] e_attr);
    e_hit = 0; e_pa = '0; e_dom = '0; e_attr = '0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] lm;
      lm = low_mask(m_size[i]);
      if (!e_hit && m_valid[i] && (((m_va[i] ^ va) & ~lm) == 0) &&
          (!m_ng[i] || m_asid[i] == asid)) begin
        e_hit  = 1;
        e_pa   = (m_pa[i] & ~lm) | (va & lm);
        e_dom  = m_dom[i];
        e_attr = m_attr[i];
      end
    end
  endtask

  task automatic step(input logic [31:0] va, input logic [7:0] asid,
                      input logic f, input logic [31:0] a_fva, input logic [31:0] a_fpa,
                      input logic [1:0] a_fsz, input logic a_fng, input logic [7:0] a_fasid,
                      input logic [3:0] a_fdom, input logic [5:0] a_fattr,
                      input logic fl, input string tag);
    logic        e_hit;
    logic [31:0] e_pa;
    logic [3:0]  e_dom;
    logic [5:0]  e_attr;
    @(negedge clk);
    lk_va = va; lk_asid = asid; fill = f; fva = a_fva; fpa = a_fpa; fsz = a_fsz;
    fng = a_fng; fasid = a_fasid; fdom = a_fdom; fattr = a_fattr; flush = fl;
    #2;
    expect_lookup(va, asid, e_hit, e_pa, e_dom, e_attr);
    n_vec++;
    if (hit !== e_hit || pa !== e_pa || dom !== e_dom || attr !== e_attr) begin
      n_fail++;
      $display("FAIL %s va=%h asid=%h: got hit=%b pa=%h dom=%h attr=%h exp hit=%b pa=%h dom=%h attr=%h",
               tag, va, asid, hit, pa, dom, attr, e_hit, e_pa, e_dom, e_attr);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < 32; i++) m_valid[i] = 0;
    end else if (f) begin
      m_valid[m_ptr] = 1; m_size[m_ptr] = a_fsz; m_ng[m_ptr] = a_fng;
      m_asid[m_ptr] = a_fasid; m_va[m_ptr] = a_fva; m_pa[m_ptr] = a_fpa;
      m_dom[m_ptr] = a_fdom; m_attr[m_ptr] = a_fattr;
      m_ptr = (m_ptr + 1) % 32;
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input string tag);
    step(va, asid, 0, '0, '0, '0, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic put(input logic [31:0] va, input logic [31:0] p, input logic [1:0] sz,
                     input logic ng, input logic [7:0] asid, input logic [3:0] d,
                     input logic [5:0] at);
    step(32'h0, 8'h0, 1, va, p, sz, ng, asid, d, at, 0, "R9");
  endtask

  logic [31:0] pool [8];

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin
      m_valid[i] = 0; m_size[i] = 0; m_ng[i] = 0; m_asid[i] = 0;
      m_va[i] = 0; m_pa[i] = 0; m_dom[i] = 0; m_attr[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    look(32'h1234_5678, 8'h01, "R1");
    look(32'h0000_0000, 8'h00, "R1");

    // R2 R3 R4: global supersection, any ASID
    put(32'hAB00_0000, 32'h1200_0000, 2'd3, 0, 8'h02, 4'h5, 6'h2A);
    look(32'hAB34_5678, 8'h09, "R2");
    look(32'hABFF_FFFF, 8'h33, "R4");
    look(32'hAC00_0000, 8'h09, "R2");

    // R5: process-specific 4K page
    put(32'h0040_1000, 32'h8000_2000, 2'd0, 1, 8'h07, 4'h3, 6'h11);
    look(32'h0040_1ABC, 8'h07, "R5");
    look(32'h0040_1ABC, 8'h08, "R5");
    look(32'h0040_2ABC, 8'h07, "R2");

    // R3 R6: 1 MB section and 64 KB page
    put(32'h3210_0000, 32'hFED0_0000, 2'd2, 0, 8'h00, 4'hA, 6'h3F);
    look(32'h321A_BCDE, 8'h01, "R3");
    put(32'h6543_0000, 32'h0987_0000, 2'd1, 0, 8'h00, 4'h1, 6'h05);
    look(32'h6543_F00D, 8'h01, "R6");
    look(32'h6544_F00D, 8'h01, "R6");

    // R7 R8: fill and lookup in the same cycle see the old contents
    step(32'h5550_0123, 8'h01, 1, 32'h5550_0000, 32'h7770_0000, 2'd2, 0, 8'h0,
         4'h6, 6'h01, 0, "R8");
    look(32'h5550_0123, 8'h01, "R7");

    // R11: overlapping 64K then 4K, lowest slot wins
    put(32'h7777_0000, 32'hA000_0000, 2'd1, 0, 8'h0, 4'h2, 6'h02);
    put(32'h7777_1000, 32'hB000_0000, 2'd0, 0, 8'h0, 4'h4, 6'h04);
    look(32'h7777_1234, 8'h00, "R11");

    // R10 R12: flush together with fill drops the fill
    step(32'h7777_1234, 8'h00, 1, 32'h1111_1000, 32'h2222_2000, 2'd0, 0, 8'h0,
         4'h1, 6'h01, 1, "R10");
    look(32'h7777_1234, 8'h00, "R10");
    look(32'h1111_1000, 8'h00, "R10");

    // R9 R12: 33 fills from current pointer evict the first one
    for (int i = 0; i < 33; i++)
      put(32'h0100_0000 + (i << 12), 32'h4000_0000 + (i << 12), 2'd0, 0, 8'h0,
          4'(i), 6'(i));
    look(32'h0100_0000, 8'h00, "R9");
    look(32'h0100_1000, 8'h00, "R9");
    look(32'h0102_0000, 8'h00, "R9");

    // random phase
    for (int i = 0; i < 8; i++) pool[i] = $urandom;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] va;
      logic [31:0] fv;
      logic        f, fl;
      va = pool[$urandom % 8] ^ ($urandom & low_mask(2'($urandom)));
      fv = pool[$urandom % 8] ^ ($urandom & low_mask(2'($urandom)));
      f  = ($urandom % 10) < 3;
      fl = ($urandom % 200) == 0;
      step(va, 8'($urandom % 3 + 1), f, fv, $urandom, 2'($urandom), 1'($urandom),
           8'($urandom % 3 + 1), 4'($urandom), 6'($urandom), fl, "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule